// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block sits between a synchronous request source and an asynchronous DRAM whose address pins are shared by row and column. A request carries a valid flag, a write flag, a full word address, write data and a per-request choice of output-enable ordering for reads. The sequencer places the upper half of the address on the shared pins as the strobe RAS_L falls, then places the lower half as CAS_L falls. It drives WE_L, OE_L and the write-data bus around that. When a read completes, it returns the data with a one-cycle completion pulse.

After an access the row stays open. A later request to the same row is served by a CAS-only page cycle. A request to another row closes the open row and reopens it only once precharge and row-cycle minimums are met. Every nanosecond timing parameter is turned into a clock-cycle count by rounding up. The exception is the refresh interval, which must be a ceiling on time and so is rounded down. A refresh timer spreads one RAS-only refresh per row across the refresh period. A pending refresh wins over new requests, and the request side sees ready held low whenever the sequencer is busy or a refresh waits.

Top module: `pgdram_seq`

## Requirements
- R1: The row on the DRAM address pins when RAS_L falls is request address bits [2*HALF_W-1:HALF_W]. The column on the pins when CAS_L falls is bits [HALF_W-1:0].
- R2: CAS_L is low only while RAS_L is low, and RAS_L does not rise while CAS_L is low.
- R3: Two RAS_L falling edges are at least ceil(T_RC_NS/CLK_NS) cycles apart, and RAS_L stays high at least ceil(T_RP_NS/CLK_NS) cycles before each fall.
- R4: Read data is captured no earlier than ceil(T_RAC_NS/CLK_NS) cycles after RAS_L fell and ceil(T_CAC_NS/CLK_NS) cycles after CAS_L fell. It is presented on rsp_rdata with rsp_done high for exactly one cycle.
- R5: Two CAS_L falling edges are at least ceil(T_PC_NS/CLK_NS) cycles apart.
- R6: A request to the row that is already open causes no RAS_L edge; only CAS_L toggles.
- R7: When req_late_oe is 0, a read has OE_L low before CAS_L falls. When it is 1, OE_L falls after CAS_L, and data is captured no earlier than ceil(T_CAC_NS/CLK_NS) cycles after OE_L fell.
- R8: A write drives WE_L low and dq_wr_en high with the data before CAS_L falls. OE_L and WE_L are never low together. Written data reads back unchanged.
- R9: RAS-only refresh cycles (RAS_L pulses with no CAS_L fall) visit rows 0,1,2,... in order, wrapping. Successive refreshes are no more than floor(REF_PERIOD_NS/2^HALF_W/CLK_NS) cycles apart plus the length of one access.
- R10: A pending refresh is served before a new request and closes any open row. The next access after a refresh therefore activates its row again.
- R11: A request to a row other than the open one closes that row and activates the new row exactly once.
- R12: req_ready is low from the cycle after a request is accepted until the sequencer returns to idle with no refresh pending.
- R13: After reset all four strobes are high, req_ready is high and rsp_done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_late_oe | input | 1 | Read ordering: 1 = OE_L after CAS_L |
| req_addr | input | 2*HALF_W | Word address, row in the upper half |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted on a cycle with req_valid high |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dram_addr | output | HALF_W | Multiplexed row/column address |
| dq_wr | output | DATA_W | Data toward the DRAM |
| dq_wr_en | output | 1 | dq_wr is driven |
| dq_rd | input | DATA_W | Data from the DRAM |

## Verification
The sequencer is driven with back-to-back requests that mix same-row hits, changes of row, early and late reads, and writes. These patterns separate the page path, which must leave RAS_L alone, from the close-and-reopen path, and they show whether each ordering of OE_L is honoured. A DRAM model in the bench returns a poison word whenever it is sampled before the row, column or output-enable access time has elapsed, so a capture that comes too early shows up as wrong data. Long idle stretches and accesses placed right after a refresh show the refresh order, the refresh spacing and the forced row reopen.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_REF,
    ST_COL,
    ST_XFER,
    ST_LATE
  } seq_state_t;

  // indices of the strobe events whose age is tracked
  localparam int EV_RASF = 0;
  localparam int EV_RASR = 1;
  localparam int EV_CASF = 2;
  localparam int EV_OEF  = 3;
  localparam int EV_NUM  = 4;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pgdram_since.sv
module pgdram_since #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  // saturating count of edges since the last clear; saturated after reset
  always_ff @(posedge clk) begin
    if (rst)              cnt <= '1;
    else if (clr)         cnt <= '0;
    else if (cnt != '1)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pgdram_ref_timer.sv
module pgdram_ref_timer #(
  parameter int PERIOD = 3125
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = $clog2(PERIOD + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == W'(PERIOD - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/pgdram_seq.sv
module pgdram_seq
  import pgdram_pkg::*;
#(
  parameter int CLK_NS        = 10,
  parameter int HALF_W        = 8,
  parameter int DATA_W        = 16,
  parameter int T_RC_NS       = 110,
  parameter int T_RAC_NS      = 60,
  parameter int T_CAC_NS      = 15,
  parameter int T_PC_NS       = 35,
  parameter int T_RP_NS       = 40,
  parameter int REF_PERIOD_NS = 8_000_000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic                  req_late_oe,
  input  logic [2*HALF_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  req_ready,
  output logic                  rsp_done,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic                  ras_n,
  output logic                  cas_n,
  output logic                  we_n,
  output logic                  oe_n,
  output logic [HALF_W-1:0]     dram_addr,
  output logic [DATA_W-1:0]     dq_wr,
  output logic                  dq_wr_en,
  input  logic [DATA_W-1:0]     dq_rd
);
  localparam int AW     = 2 * HALF_W;
  localparam int ROWS   = 1 << HALF_W;
  localparam int C_RC   = ns_to_cyc(T_RC_NS, CLK_NS);
  localparam int C_RAC  = ns_to_cyc(T_RAC_NS, CLK_NS);
  localparam int C_CAC  = ns_to_cyc(T_CAC_NS, CLK_NS);
  localparam int C_PC   = ns_to_cyc(T_PC_NS, CLK_NS);
  localparam int C_RP   = ns_to_cyc(T_RP_NS, CLK_NS);
  localparam int C_RAS  = (C_RC > C_RP + 1) ? (C_RC - C_RP) : 1;
  localparam int C_REFI = imax(1, REF_PERIOD_NS / ROWS / CLK_NS);
  localparam int C_MAX  = imax(imax(imax(C_RC, C_RAC), imax(C_CAC, C_PC)), C_RP);
  localparam int CNT_W  = $clog2(C_MAX + 1);

  // ---------------- state ----------------
  seq_state_t          st, st_d;
  logic                row_open, open_d;
  logic [HALF_W-1:0]   open_row, orow_d;
  logic [HALF_W-1:0]   ref_row, rref_d;
  logic                ref_pend, pend_clr;
  logic                tgt_ref, tref_d;
  logic                cur_w, cw_d;
  logic                cur_late, cl_d;
  logic [AW-1:0]       cur_addr, ca_d;
  logic [DATA_W-1:0]   cur_data, cdat_d;

  logic                ras_d, cas_d, we_d, oe_d, wen_d, done_d;
  logic [HALF_W-1:0]   addr_d;
  logic [DATA_W-1:0]   dq_d, rdata_d;

  logic                ref_tick;
  logic [EV_NUM-1:0]   ev_clr;
  logic [CNT_W-1:0]    ev_cnt [EV_NUM];

  // ---------------- event age counters ----------------
  assign ev_clr[EV_RASF] = ras_n & ~ras_d;
  assign ev_clr[EV_RASR] = ~ras_n & ras_d;
  assign ev_clr[EV_CASF] = cas_n & ~cas_d;
  assign ev_clr[EV_OEF]  = oe_n & ~oe_d;

  for (genvar g = 0; g < EV_NUM; g++) begin : g_age
    pgdram_since #(.W(CNT_W)) u_age (
      .clk (clk),
      .rst (rst),
      .clr (ev_clr[g]),
      .cnt (ev_cnt[g])
    );
  end

  pgdram_ref_timer #(.PERIOD(C_REFI)) u_ref_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (ref_tick)
  );

  // an event at the coming edge is legal when the age is at least C-1
  logic rc_ok, rp_ok, pc_ok, rac_ok, cac_ok, oe_ok, ras_ok;
  assign rc_ok  = int'(ev_cnt[EV_RASF]) >= C_RC  - 1;
  assign rac_ok = int'(ev_cnt[EV_RASF]) >= C_RAC - 1;
  assign ras_ok = int'(ev_cnt[EV_RASF]) >= C_RAS - 1;
  assign rp_ok  = int'(ev_cnt[EV_RASR]) >= C_RP  - 1;
  assign pc_ok  = int'(ev_cnt[EV_CASF]) >= C_PC  - 1;
  assign cac_ok = int'(ev_cnt[EV_CASF]) >= C_CAC - 1;
  assign oe_ok  = int'(ev_cnt[EV_OEF])  >= C_CAC - 1;

  assign req_ready = (st == ST_IDLE) && !ref_pend;

  // ---------------- next-state logic ----------------
  always_comb begin
    st_d     = st;
    ras_d    = ras_n;
    cas_d    = cas_n;
    we_d     = we_n;
    oe_d     = oe_n;
    addr_d   = dram_addr;
    dq_d     = dq_wr;
    wen_d    = dq_wr_en;
    done_d   = 1'b0;
    rdata_d  = rsp_rdata;
    open_d   = row_open;
    orow_d   = open_row;
    rref_d   = ref_row;
    tref_d   = tgt_ref;
    cw_d     = cur_w;
    cl_d     = cur_late;
    ca_d     = cur_addr;
    cdat_d   = cur_data;
    pend_clr = 1'b0;

    unique case (st)
      ST_IDLE: begin
        if (ref_pend) begin
          tref_d = 1'b1;
          st_d   = ST_ACT;
          if (row_open) begin
            ras_d  = 1'b1;
            open_d = 1'b0;
          end
        end else if (req_valid) begin
          cw_d   = req_write;
          cl_d   = req_late_oe;
          ca_d   = req_addr;
          cdat_d = req_wdata;
          tref_d = 1'b0;
          if (row_open && (req_addr[AW-1:HALF_W] == open_row)) begin
            st_d = ST_COL;
            if (req_write) begin
              we_d  = 1'b0;
              wen_d = 1'b1;
              dq_d  = req_wdata;
            end else if (!req_late_oe) begin
              oe_d = 1'b0;
            end
          end else begin
            st_d = ST_ACT;
            if (row_open) begin
              ras_d  = 1'b1;
              open_d = 1'b0;
            end
          end
        end
      end

      ST_ACT: begin
        if (rp_ok && rc_ok) begin
          ras_d = 1'b0;
          if (tgt_ref) begin
            addr_d   = ref_row;
            pend_clr = 1'b1;
            st_d     = ST_REF;
          end else begin
            addr_d = cur_addr[AW-1:HALF_W];
            open_d = 1'b1;
            orow_d = cur_addr[AW-1:HALF_W];
            st_d   = ST_COL;
            if (cur_w) begin
              we_d  = 1'b0;
              wen_d = 1'b1;
              dq_d  = cur_data;
            end else if (!cur_late) begin
              oe_d = 1'b0;
            end
          end
        end
      end

      ST_REF: begin
        if (ras_ok) begin
          ras_d  = 1'b1;
          rref_d = ref_row + 1'b1;
          st_d   = ST_IDLE;
        end
      end

      ST_COL: begin
        if (pc_ok) begin
          cas_d  = 1'b0;
          addr_d = cur_addr[HALF_W-1:0];
          st_d   = ST_XFER;
        end
      end

      ST_XFER: begin
        if (cur_w) begin
          if (cac_ok) begin
            cas_d  = 1'b1;
            we_d   = 1'b1;
            wen_d  = 1'b0;
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end
        end else if (cur_late) begin
          oe_d = 1'b0;
          st_d = ST_LATE;
        end else if (rac_ok && cac_ok) begin
          rdata_d = dq_rd;
          cas_d   = 1'b1;
          oe_d    = 1'b1;
          done_d  = 1'b1;
          st_d    = ST_IDLE;
        end
      end

      ST_LATE: begin
        if (rac_ok && oe_ok) begin
          rdata_d = dq_rd;
          cas_d   = 1'b1;
          oe_d    = 1'b1;
          done_d  = 1'b1;
          st_d    = ST_IDLE;
        end
      end

      default: st_d = ST_IDLE;
    endcase
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      dram_addr <= '0;
      dq_wr     <= '0;
      dq_wr_en  <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
      row_open  <= 1'b0;
      open_row  <= '0;
      ref_row   <= '0;
      ref_pend  <= 1'b0;
      tgt_ref   <= 1'b0;
      cur_w     <= 1'b0;
      cur_late  <= 1'b0;
      cur_addr  <= '0;
      cur_data  <= '0;
    end else begin
      st        <= st_d;
      ras_n     <= ras_d;
      cas_n     <= cas_d;
      we_n      <= we_d;
      oe_n      <= oe_d;
      dram_addr <= addr_d;
      dq_wr     <= dq_d;
      dq_wr_en  <= wen_d;
      rsp_done  <= done_d;
      rsp_rdata <= rdata_d;
      row_open  <= open_d;
      open_row  <= orow_d;
      ref_row   <= rref_d;
      tgt_ref   <= tref_d;
      cur_w     <= cw_d;
      cur_late  <= cl_d;
      cur_addr  <= ca_d;
      cur_data  <= cdat_d;
      if (ref_tick)      ref_pend <= 1'b1;
      else if (pend_clr) ref_pend <= 1'b0;
    end
  end

endmodule

// File: rtl/pgdram_seq_chk.sv
module pgdram_seq_chk
  import pgdram_pkg::*;
#(
  parameter int CLK_NS  = 10,
  parameter int T_RC_NS = 110,
  parameter int T_PC_NS = 35
) (
  input logic clk,
  input logic rst,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_done
);
  localparam int C_RC = ns_to_cyc(T_RC_NS, CLK_NS);
  localparam int C_PC = ns_to_cyc(T_PC_NS, CLK_NS);
  localparam int GMAX = 1000;

  logic ras_p, cas_p;
  int   ras_gap, cas_gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_p   <= 1'b1;
      cas_p   <= 1'b1;
      ras_gap <= GMAX;
      cas_gap <= GMAX;
    end else begin
      ras_p   <= ras_n;
      cas_p   <= cas_n;
      ras_gap <= (ras_p && !ras_n) ? 1 : ((ras_gap < GMAX) ? ras_gap + 1 : ras_gap);
      cas_gap <= (cas_p && !cas_n) ? 1 : ((cas_gap < GMAX) ? cas_gap + 1 : cas_gap);
    end
  end

  // R2
  cas_in_row_chk: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !ras_n);

  // R2
  row_held_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> $past(cas_n));

  // R3
  row_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (ras_p && !ras_n) |-> ras_gap >= C_RC);

  // R5
  page_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (cas_p && !cas_n) |-> cas_gap >= C_PC);

  // R8
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n && !we_n));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R12
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

endmodule

bind pgdram_seq pgdram_seq_chk #(
  .CLK_NS  (CLK_NS),
  .T_RC_NS (T_RC_NS),
  .T_PC_NS (T_PC_NS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .oe_n      (oe_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_done  (rsp_done)
);

// File: tb/sim_pgdram_seq.sv
`timescale 1ns/1ps
module sim_pgdram_seq;
  localparam int HW     = 6;
  localparam int AW     = 2 * HW;
  localparam int DW     = 16;
  localparam int NWORDS = 1 << AW;
  localparam int CLKP   = 10;

  function automatic int cyc(input int ns);
    return (ns + CLKP - 1) / CLKP;
  endfunction

  localparam int B_RC   = cyc(110);
  localparam int B_RAC  = cyc(60);
  localparam int B_CAC  = cyc(15);
  localparam int B_PC   = cyc(35);
  localparam int B_RP   = cyc(40);
  localparam int B_REFI = 8_000_000 / (1 << HW) / CLKP;
  localparam int B_REFLIM = B_REFI + 64;
  localparam logic [DW-1:0] POISON = 16'hDEAD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_late_oe = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_done, ras_n, cas_n, we_n, oe_n, dq_wr_en;
  logic [DW-1:0] rsp_rdata, dq_wr;
  logic [HW-1:0] dram_addr;
  logic [DW-1:0] dq_rd = POISON;

  always #(CLKP/2) clk = ~clk;

  pgdram_seq #(.CLK_NS(CLKP), .HALF_W(HW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_late_oe(req_late_oe), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .dram_addr(dram_addr), .dq_wr(dq_wr), .dq_wr_en(dq_wr_en), .dq_rd(dq_rd)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] init_word(input int a);
    return DW'(a * 40503 + 23130);
  endfunction

  // ---------------- DRAM model (observes at the falling clock edge) ----------------
  logic [DW-1:0] dmem    [NWORDS];
  logic [DW-1:0] ref_mem [NWORDS];
  logic m_ras_p = 1'b1, m_cas_p = 1'b1, m_oe_p = 1'b1;
  logic [HW-1:0] m_row = '0, m_col = '0;
  int since_rasf = 1000, since_rasr = 1000, since_casf = 1000, since_oef = 1000;
  int since_ref = 0;
  bit cas_seen = 1'b0, oe_at_cas = 1'b0;
  int act_cnt = 0, ref_cnt = 0, exp_ref_row = 0;
  int v_rc = 0, v_rp = 0, v_pc = 0, v_cas = 0, v_oewe = 0, v_wdat = 0, v_refrow = 0, v_refgap = 0;

  always @(negedge clk) begin
    if (rst) begin
      since_ref = 0;
    end else begin
      if (since_rasf < 1000) since_rasf++;
      if (since_rasr < 1000) since_rasr++;
      if (since_casf < 1000) since_casf++;
      if (since_oef  < 1000) since_oef++;
      since_ref++;
      if (m_ras_p && !ras_n) begin
        if (since_rasf < B_RC + 1) v_rc++;
        if (since_rasr < B_RP + 1) v_rp++;
        m_row = dram_addr; since_rasf = 1; cas_seen = 1'b0;
      end
      if (!m_ras_p && ras_n) begin
        since_rasr = 1;
        if (!cas_seen) begin
          ref_cnt++;
          if (int'(m_row) != exp_ref_row) v_refrow++;
          if (since_ref > B_REFLIM) v_refgap++;
          exp_ref_row = (exp_ref_row + 1) % (1 << HW);
          since_ref = 0;
        end
      end
      if (!cas_n && ras_n) v_cas++;
      if (m_cas_p && !cas_n) begin
        if (since_casf < B_PC + 1) v_pc++;
        if (!cas_seen) act_cnt++;
        cas_seen = 1'b1;
        m_col = dram_addr; since_casf = 1; oe_at_cas = !oe_n;
        if (!we_n) begin
          if (!dq_wr_en) v_wdat++;
          dmem[{m_row, m_col}] = dq_wr;
        end
      end
      if (m_oe_p && !oe_n) since_oef = 1;
      if (!oe_n && !we_n) v_oewe++;
      if (!ras_n && !cas_n && !oe_n && since_rasf >= B_RAC &&
          since_casf >= B_CAC && since_oef >= B_CAC)
        dq_rd = dmem[{m_row, m_col}];
      else
        dq_rd = POISON;
    end
    m_ras_p = ras_n; m_cas_p = cas_n; m_oe_p = oe_n;
  end

  // ---------------- watchdog ----------------
  int cyc_n = 0;
  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 190000) begin
      failures++;
      checks++;
      $display("FAIL R12 watchdog actual=%0d expected=%0d", cyc_n, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- request driver ----------------
  bit b_open = 1'b0;
  logic [HW-1:0] b_row = '0;
  int b_refs = 0;
  int ready_chks = 0;

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic access(input bit w, input bit late, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int acts0, delta;
    bit hit_exp, ref_changed;
    while (!req_ready) step();
    acts0 = act_cnt;
    req_valid = 1'b1; req_write = w; req_late_oe = late; req_addr = a; req_wdata = d;
    step();
    req_valid = 1'b0;
    if (ready_chks < 30) begin
      ready_chks++;
      chk(!req_ready, "R12 ready low after accept", req_ready, 0);
    end
    while (!rsp_done) step();
    if (!w) begin
      chk(rsp_rdata == ref_mem[a], late ? "R7 R4 late read data" : "R1 R4 read data",
          rsp_rdata, ref_mem[a]);
      chk(oe_at_cas == !late, "R7 OE order at CAS fall", oe_at_cas, !late);
    end else begin
      ref_mem[a] = d;
    end
    ref_changed = (ref_cnt != b_refs);
    hit_exp = b_open && (a[AW-1:HW] == b_row) && !ref_changed;
    delta = act_cnt - acts0;
    if (hit_exp)          chk(delta == 0, "R6 page hit activations", delta, 0);
    else if (ref_changed && b_open && a[AW-1:HW] == b_row)
                          chk(delta == 1, "R10 reopen after refresh", delta, 1);
    else                  chk(delta == 1, "R11 activation count", delta, 1);
    b_open = 1'b1; b_row = a[AW-1:HW]; b_refs = ref_cnt;
  endtask

  initial begin
    int r0;
    for (int i = 0; i < NWORDS; i++) begin
      dmem[i] = init_word(i);
      ref_mem[i] = init_word(i);
    end
    void'($urandom(32'h1234_5EED));
    repeat (4) step();
    rst = 1'b0;
    step();
    // R13 reset state
    chk({ras_n, cas_n, we_n, oe_n} == 4'hF, "R13 strobes idle", {ras_n, cas_n, we_n, oe_n}, 4'hF);
    chk(req_ready == 1'b1, "R13 ready", req_ready, 1);
    chk(rsp_done == 1'b0, "R13 done", rsp_done, 0);

    // directed: address split, early/late read, write, hit, miss
    access(1'b0, 1'b0, {6'd5, 6'd3}, '0);
    access(1'b1, 1'b0, {6'd5, 6'd9}, 16'h1357);
    access(1'b0, 1'b1, {6'd5, 6'd9}, '0);
    access(1'b0, 1'b0, {6'd9, 6'd5}, '0);
    access(1'b0, 1'b1, {6'd9, 6'd5}, '0);
    access(1'b1, 1'b0, {6'd9, 6'd63}, 16'hFFFF);
    access(1'b0, 1'b0, {6'd63, 6'd0}, '0);
    access(1'b0, 1'b0, {6'd9, 6'd63}, '0);

    // directed: refresh with a row open, then the same row again
    r0 = ref_cnt;
    access(1'b0, 1'b0, {6'd12, 6'd1}, '0);
    while (ref_cnt == r0) step();
    access(1'b0, 1'b0, {6'd12, 6'd2}, '0);

    // constrained random mix
    for (int n = 0; n < 1800; n++) begin
      logic [HW-1:0] row, col;
      bit w, late;
      row  = ($urandom % 8 == 0) ? HW'($urandom) : HW'($urandom % 3);
      col  = HW'($urandom);
      w    = ($urandom % 3 == 0);
      late = $urandom % 2;
      access(w, late, {row, col}, DW'($urandom));
    end

    // idle stretch so refresh runs unattended
    repeat (B_REFI + 2000) step();

    chk(v_cas == 0, "R2 CAS low without RAS", v_cas, 0);
    chk(v_rc == 0, "R3 row cycle", v_rc, 0);
    chk(v_rp == 0, "R3 precharge", v_rp, 0);
    chk(v_pc == 0, "R5 page cycle", v_pc, 0);
    chk(v_oewe == 0, "R8 OE and WE together", v_oewe, 0);
    chk(v_wdat == 0, "R8 write data not driven", v_wdat, 0);
    chk(v_refrow == 0, "R9 refresh row order", v_refrow, 0);
    chk(v_refgap == 0, "R9 refresh spacing", v_refgap, 0);
    chk(since_ref <= B_REFLIM, "R9 refresh overdue", since_ref, B_REFLIM);
    chk(ref_cnt >= 3, "R9 refresh count", ref_cnt, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule